// File: doc/BRIEF.md
# Two-Plane Stacked-Hit Coincidence Trigger Array

This block produces trigger primitives for one readout chip that looks at two stacked sensor planes. On every bunch-clock cycle it receives a binary hit map for the upper plane and one for the lower plane. Each map covers a matrix of `ROWS` x `COLS` pixels, 4 x 160 by default. The upper map goes through a wide-cluster veto first. Any lit pixel that belongs to an 8-connected group of three or more lit pixels is cleared. Single hits and two-pixel pairs are kept.

Each lower-plane pixel then compares its own hit against a small window of the cleaned upper map. The pixel raises its trigger bit when its own hit and at least one hit in the window are both present. A per-pixel configuration selects the shape of that window and can mask the pixel. The configuration is shifted into a daisy chain on its own clock and becomes active on a load strobe.

A chip in slave mode produces no trigger bits. It still drives out its cleaned upper map so that a neighbouring master can use it. The whole path runs as a two-stage pipeline: the cleaned map appears one cycle after the inputs, and the trigger map appears two cycles after them.

Top module: `tpg_stack_trigger`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, `clean_map` and `trig_map` are cleared at that edge. The active configuration is also cleared: every pixel unmasked and every pixel using the 3x3 window.
- R2: A lit upper-plane pixel appears in `clean_map` only if its 8-connected group of lit pixels has one or two members. Every member of a group of three or more is removed.
- R3: Positions outside the matrix read as unlit, for both the cluster veto and the window match. There is no wrap between the last column of one row and the first column of the next.
- R4: With the 3x3 window selected, bit (r,c) of `trig_map` is 1 exactly when the lower hit (r,c) is set and at least one cleaned upper pixel in rows r-1..r+1 and columns c-1..c+1 is set.
- R5: With the wide window selected, the match uses columns c-2..c+2 in rows r and r+1 only. Row r-1 does not count.
- R6: While `master_en` is 0, every bit of `trig_map` is 0. `clean_map` is still produced as usual.
- R7: Inputs sampled at rising edge k appear in `clean_map` after edge k and in `trig_map` after edge k+1.
- R8: On each rising edge of `cfg_clk`, the configuration chain shifts by one bit from `cfg_sin` toward `cfg_sout`. Bits are sent most significant first. In the 2*NPIX-bit word, pixel p = r*COLS+c owns bit 2p (mask) and bit 2p+1 (window select, 1 = wide). `cfg_sout` shows the bit shifted in 2*NPIX edges earlier. Shifting changes no behaviour until `cfg_load` is high at a `clk` edge.
- R9: A pixel whose mask bit is 1 treats its lower-plane hit as 0 and never triggers.
- R10: An upper-plane hit removed by the cluster veto cannot cause a trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1 = master (triggers enabled), 0 = slave |
| up_hits | input | ROWS*COLS | Upper-plane hit map, bit r*COLS+c |
| lo_hits | input | ROWS*COLS | Lower-plane hit map, bit r*COLS+c |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_sin | input | 1 | Serial configuration input |
| cfg_load | input | 1 | Copies the shifted chain into the active configuration |
| cfg_sout | output | 1 | Serial output at the end of the chain |
| clean_map | output | ROWS*COLS | Registered cleaned upper map |
| trig_map | output | ROWS*COLS | Registered trigger bits |

## Verification
The hardest situation to reach is a lower-plane pixel that uses the wide window while its neighbours keep the square one. That state exists only after a full 1280-bit serial word has been shifted in and loaded. The bench builds such words with the select bit set for a few chosen pixels. It then places upper hits that only one of the two window shapes would accept. Edge pixels get hits in the last column next to first-column hits of the next row, which exposes any flat-index wrap. To show that shifting alone does nothing before the load strobe, the bench re-shifts the chain without loading and checks that the trigger result is unchanged.

// File: rtl/tpg_pkg.sv
// Package: shared constants and types for the stacked-hit trigger array.
// Assumes a pixel is addressed by flat index r*COLS+c throughout the block.
package tpg_pkg;
    localparam int CFG_W    = 2;   // configuration bits per pixel
    localparam int CFG_MASK = 0;   // bit position of the mask flag
    localparam int CFG_SEL  = 1;   // bit position of the window select

    typedef enum logic {
        WIN_SQUARE = 1'b0,         // 3x3 window around the facing pixel
        WIN_WIDE   = 1'b1          // 5 columns by rows r and r+1
    } win_sel_e;
endpackage

// File: rtl/tpg_cfg_chain.sv
// Per-pixel configuration: a daisy chain of CFG_W-bit shift cells on
// cfg_clk, plus an active copy taken on clk when cfg_load is high.
// Assumes the chain is quiet while cfg_load is asserted.
module tpg_cfg_chain
    import tpg_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 160
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_clk,
    input  logic                  cfg_sin,
    input  logic                  cfg_load,
    output logic                  cfg_sout,
    output logic [ROWS*COLS-1:0]  mask_vec,
    output logic [ROWS*COLS-1:0]  sel_vec
);
    localparam int NPIX = ROWS * COLS;
    localparam int CW   = NPIX * CFG_W;

    logic [NPIX:0] link;
    logic [CW-1:0] shadow;

    assign link[0] = cfg_sin;

    for (genvar p = 0; p < NPIX; p++) begin : g_cell
        logic [CFG_W-1:0] sh;
        // Shift one bit through this pixel's cell.
        always_ff @(posedge cfg_clk) begin
            sh <= {sh[CFG_W-2:0], link[p]};
        end
        assign link[p+1]                  = sh[CFG_W-1];
        assign shadow[p*CFG_W +: CFG_W]   = sh;
    end

    assign cfg_sout = link[NPIX];

    // Reset or load the active configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_vec <= '0;
            sel_vec  <= '0;
        end else if (cfg_load) begin
            for (int p = 0; p < NPIX; p++) begin
                mask_vec[p] <= shadow[p*CFG_W + CFG_MASK];
                sel_vec[p]  <= shadow[p*CFG_W + CFG_SEL];
            end
        end
    end
endmodule

// File: rtl/tpg_cluster_veto.sv
// Wide-cluster veto (combinational). A lit pixel with two or more lit
// 8-neighbours is a seed; any lit pixel that is a seed or touches one is
// cleared, which removes exactly the 8-connected groups of 3 or more.
// Assumes off-matrix positions are unlit.
module tpg_cluster_veto #(
    parameter int ROWS = 4,
    parameter int COLS = 160
) (
    input  logic [ROWS*COLS-1:0] hits,
    output logic [ROWS*COLS-1:0] clean
);
    localparam int NPIX = ROWS * COLS;

    logic [COLS+1:0] hp [ROWS+2];
    logic [COLS+1:0] sp [ROWS+2];
    logic [NPIX-1:0] seed;

    // Place hits into a map with a one-pixel unlit border.
    always_comb begin
        for (int r = 0; r < ROWS + 2; r++) hp[r] = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                hp[r+1][c+1] = hits[r*COLS + c];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row_s
        for (genvar c = 0; c < COLS; c++) begin : g_col_s
            logic [7:0] nb;
            assign nb = {hp[r][c+2:c], hp[r+1][c], hp[r+1][c+2], hp[r+2][c+2:c]};
            assign seed[r*COLS + c] = hp[r+1][c+1] && ($countones(nb) >= 2);
        end
    end

    // Place seeds into a bordered map.
    always_comb begin
        for (int r = 0; r < ROWS + 2; r++) sp[r] = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                sp[r+1][c+1] = seed[r*COLS + c];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row_k
        for (genvar c = 0; c < COLS; c++) begin : g_col_k
            assign clean[r*COLS + c] = hp[r+1][c+1] &
                ~(|sp[r][c+2:c] | |sp[r+1][c+2:c] | |sp[r+2][c+2:c]);
        end
    end
endmodule

// File: rtl/tpg_window_match.sv
// Window match (combinational). Each lower pixel ANDs its hit with the OR
// of a window of the cleaned upper map; the window is 3x3 or 5 wide by
// rows r and r+1, chosen per pixel. Off-matrix positions read as unlit.
module tpg_window_match
    import tpg_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 160
) (
    input  logic [ROWS*COLS-1:0] up_clean,
    input  logic [ROWS*COLS-1:0] lo_hit,
    input  logic [ROWS*COLS-1:0] sel_vec,
    output logic [ROWS*COLS-1:0] match
);
    logic [COLS+3:0] cp [ROWS+2];

    // Place cleaned upper hits into a map with a 1-row, 2-column border.
    always_comb begin
        for (int r = 0; r < ROWS + 2; r++) cp[r] = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                cp[r+1][c+2] = up_clean[r*COLS + c];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic win_sq, win_wd;
            assign win_sq = |cp[r][c+3:c+1] | |cp[r+1][c+3:c+1] | |cp[r+2][c+3:c+1];
            assign win_wd = |cp[r+1][c+4:c] | |cp[r+2][c+4:c];
            assign match[r*COLS + c] = lo_hit[r*COLS + c] &
                ((sel_vec[r*COLS + c] == WIN_WIDE) ? win_wd : win_sq);
        end
    end
endmodule

// File: rtl/tpg_stack_trigger.sv
// Top: two-stage trigger pipeline. Stage 1 registers the cleaned upper
// map and the masked lower map; stage 2 registers the window match gated
// by master mode. Assumes master_en is static during operation.
module tpg_stack_trigger #(
    parameter int ROWS = 4,
    parameter int COLS = 160
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 master_en,
    input  logic [ROWS*COLS-1:0] up_hits,
    input  logic [ROWS*COLS-1:0] lo_hits,
    input  logic                 cfg_clk,
    input  logic                 cfg_sin,
    input  logic                 cfg_load,
    output logic                 cfg_sout,
    output logic [ROWS*COLS-1:0] clean_map,
    output logic [ROWS*COLS-1:0] trig_map
);
    localparam int NPIX = ROWS * COLS;

    logic [NPIX-1:0] mask_vec, sel_vec;
    logic [NPIX-1:0] clean_d, lo_q, match_d;

    tpg_cfg_chain #(.ROWS(ROWS), .COLS(COLS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_sin(cfg_sin),
        .cfg_load(cfg_load), .cfg_sout(cfg_sout),
        .mask_vec(mask_vec), .sel_vec(sel_vec)
    );

    tpg_cluster_veto #(.ROWS(ROWS), .COLS(COLS)) u_veto (
        .hits(up_hits), .clean(clean_d)
    );

    // Stage 1: cleaned upper map and masked lower map.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_map <= '0;
            lo_q      <= '0;
        end else begin
            clean_map <= clean_d;
            lo_q      <= lo_hits & ~mask_vec;
        end
    end

    tpg_window_match #(.ROWS(ROWS), .COLS(COLS)) u_match (
        .up_clean(clean_map), .lo_hit(lo_q), .sel_vec(sel_vec), .match(match_d)
    );

    // Stage 2: trigger bits, forced low in slave mode.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_map <= '0;
        else        trig_map <= master_en ? match_d : '0;
    end
endmodule

// File: rtl/tpg_stack_trigger_checker.sv
// Checker: temporal properties on the top-level ports, bound into the top.
module tpg_stack_trigger_checker #(
    parameter int ROWS = 4,
    parameter int COLS = 160
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 master_en,
    input logic [ROWS*COLS-1:0] up_hits,
    input logic [ROWS*COLS-1:0] lo_hits,
    input logic [ROWS*COLS-1:0] clean_map,
    input logic [ROWS*COLS-1:0] trig_map
);
    // R6: slave mode yields no triggers one edge later.
    assert_slave_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (trig_map == '0));

    // R2: cleaned map only holds pixels lit in the previous upper input.
    assert_clean_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((clean_map & ~$past(up_hits)) == '0));

    // R7 / R4: a trigger bit needs the lower hit two cycles earlier.
    assert_trig_needs_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((trig_map & ~$past(lo_hits, 2)) == '0));

    // R10: any trigger needs a cleaned upper hit one cycle earlier.
    assert_trig_needs_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_map) |-> $past(|clean_map));

    // R2: an empty upper input gives an empty cleaned map.
    assert_empty_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_hits == '0) |=> (clean_map == '0));
endmodule

bind tpg_stack_trigger tpg_stack_trigger_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .up_hits(up_hits),
    .lo_hits(lo_hits), .clean_map(clean_map), .trig_map(trig_map)
);

// File: tb/tpg_stack_trigger_bench.sv
module tpg_stack_trigger_bench;
    localparam int ROWS = 4;
    localparam int COLS = 160;
    localparam int NPIX = ROWS * COLS;
    localparam int CW   = 2 * NPIX;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            master_en = 1'b1;
    logic [NPIX-1:0] up_hits = '0, lo_hits = '0;
    logic            cfg_clk = 1'b0, cfg_sin = 1'b0, cfg_load = 1'b0;
    logic            cfg_sout;
    logic [NPIX-1:0] clean_map, trig_map;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    tpg_stack_trigger #(.ROWS(ROWS), .COLS(COLS)) u_tpg_stack_trigger (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .up_hits(up_hits),
        .lo_hits(lo_hits), .cfg_clk(cfg_clk), .cfg_sin(cfg_sin),
        .cfg_load(cfg_load), .cfg_sout(cfg_sout),
        .clean_map(clean_map), .trig_map(trig_map)
    );

    function automatic int px(int r, int c);
        return r * COLS + c;
    endfunction

    task automatic check_vec(string req, logic [NPIX-1:0] act, logic [NPIX-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive both maps, let both pipeline stages settle.
    task automatic apply(logic [NPIX-1:0] up, logic [NPIX-1:0] lo);
        up_hits = up;
        lo_hits = lo;
        step();
        step();
    endtask

    task automatic shift_word(logic [CW-1:0] w);
        for (int i = CW - 1; i >= 0; i--) begin
            cfg_sin = w[i];
            #1 cfg_clk = 1'b1;
            #1 cfg_clk = 1'b0;
        end
    endtask

    task automatic pulse_load();
        cfg_load = 1'b1;
        step();
        cfg_load = 1'b0;
    endtask

    // R1: reset state with busy inputs.
    task automatic t_reset();
        up_hits = '1;
        lo_hits = '1;
        rst_n = 1'b0;
        step();
        step();
        check_vec("R1 clean_map", clean_map, '0);
        check_vec("R1 trig_map", trig_map, '0);
        up_hits = '0;
        lo_hits = '0;
        rst_n = 1'b1;
        step();
    endtask

    // R2: isolated, pairs kept; lines and L shapes removed.
    task automatic t_cluster();
        logic [NPIX-1:0] up, exp;
        up = '0;
        up[px(1,10)] = 1; up[px(0,20)] = 1; up[px(1,21)] = 1;
        up[px(2,40)] = 1; up[px(2,41)] = 1; up[px(2,42)] = 1;
        up[px(0,60)] = 1; up[px(1,60)] = 1; up[px(1,61)] = 1;
        up[px(3,80)] = 1; up[px(3,82)] = 1;
        exp = '0;
        exp[px(1,10)] = 1; exp[px(0,20)] = 1; exp[px(1,21)] = 1;
        exp[px(3,80)] = 1; exp[px(3,82)] = 1;
        apply(up, '0);
        check_vec("R2 cluster veto", clean_map, exp);
        check_vec("R2 no lower hits no trigger", trig_map, '0);
    endtask

    // R3: edges and corners, no row wrap.
    task automatic t_edges();
        logic [NPIX-1:0] up, lo, exp;
        up = '0;
        up[px(0,0)] = 1; up[px(0,1)] = 1;
        up[px(3,157)] = 1; up[px(3,158)] = 1; up[px(3,159)] = 1;
        exp = '0;
        exp[px(0,0)] = 1; exp[px(0,1)] = 1;
        apply(up, '0);
        check_vec("R3 edge clusters", clean_map, exp);
        up = '0; lo = '0;
        up[px(1,0)] = 1; up[px(2,159)] = 1; up[px(3,158)] = 1;
        lo[px(0,159)] = 1; lo[px(3,0)] = 1; lo[px(3,159)] = 1; lo[px(0,0)] = 1;
        exp = '0;
        exp[px(0,0)] = 1; exp[px(3,159)] = 1;
        apply(up, lo);
        check_vec("R3 edge match no wrap", trig_map, exp);
    endtask

    // R4: square window hits and misses.
    task automatic t_square();
        logic [NPIX-1:0] up, lo, exp;
        up = '0; lo = '0;
        lo[px(1,50)] = 1; up[px(2,51)] = 1;
        lo[px(1,70)] = 1; up[px(1,72)] = 1;
        lo[px(2,90)] = 1; up[px(2,90)] = 1;
        up[px(0,110)] = 1;
        exp = '0;
        exp[px(1,50)] = 1; exp[px(2,90)] = 1;
        apply(up, lo);
        check_vec("R4 square window", trig_map, exp);
    endtask

    // R10: vetoed upper cluster cannot trigger.
    task automatic t_vetoed();
        logic [NPIX-1:0] up, lo;
        up = '0; lo = '0;
        lo[px(1,120)] = 1;
        up[px(0,119)] = 1; up[px(0,120)] = 1; up[px(0,121)] = 1;
        apply(up, lo);
        check_vec("R10 vetoed cluster", trig_map, '0);
    endtask

    // R5 / R8: wide window on selected pixels only.
    task automatic t_wide();
        logic [CW-1:0]   w;
        logic [NPIX-1:0] up, lo, exp;
        w = '0;
        w[2*px(1,30)+1] = 1; w[2*px(1,40)+1] = 1; w[2*px(3,5)+1] = 1;
        shift_word(w);
        pulse_load();
        up = '0; lo = '0;
        lo[px(1,30)] = 1; up[px(2,32)] = 1;
        lo[px(1,40)] = 1; up[px(0,40)] = 1;
        lo[px(3,5)]  = 1; up[px(3,3)]  = 1;
        lo[px(1,140)] = 1; up[px(2,142)] = 1;
        exp = '0;
        exp[px(1,30)] = 1; exp[px(3,5)] = 1;
        apply(up, lo);
        check_vec("R5 wide window", trig_map, exp);
    endtask

    // R9: masked pixel never triggers.
    task automatic t_mask();
        logic [CW-1:0]   w;
        logic [NPIX-1:0] up, lo, exp;
        w = '0;
        w[2*px(2,10)] = 1;
        shift_word(w);
        pulse_load();
        up = '0; lo = '0;
        lo[px(2,10)] = 1; up[px(2,10)] = 1;
        lo[px(2,20)] = 1; up[px(2,20)] = 1;
        exp = '0;
        exp[px(2,20)] = 1;
        apply(up, lo);
        check_vec("R9 mask bit", trig_map, exp);
    endtask

    // R8: serial output order and load gating.
    task automatic t_chain();
        logic [CW-1:0]   w;
        logic [NPIX-1:0] up, lo, exp;
        w = '0;
        w[CW-1] = 1;
        shift_word(w);
        check_bit("R8 sout first bit", cfg_sout, 1'b1);
        cfg_sin = 1'b0;
        #1 cfg_clk = 1'b1;
        #1 cfg_clk = 1'b0;
        check_bit("R8 sout second bit", cfg_sout, 1'b0);
        up = '0; lo = '0;
        lo[px(2,10)] = 1; up[px(2,10)] = 1;
        apply(up, lo);
        check_vec("R8 shift without load", trig_map, '0);
        pulse_load();
        exp = '0;
        exp[px(2,10)] = 1;
        apply(up, lo);
        check_vec("R8 after load", trig_map, exp);
    endtask

    // R6: slave mode.
    task automatic t_slave();
        logic [NPIX-1:0] up, lo;
        up = '0; lo = '0;
        up[px(1,100)] = 1; lo[px(1,100)] = 1;
        master_en = 1'b0;
        apply(up, lo);
        check_vec("R6 slave trig", trig_map, '0);
        check_vec("R6 slave clean", clean_map, up);
        master_en = 1'b1;
    endtask

    // R7: pipeline timing.
    task automatic t_latency();
        logic [NPIX-1:0] a;
        apply('0, '0);
        a = '0;
        a[px(1,5)] = 1;
        up_hits = a;
        lo_hits = a;
        step();
        check_vec("R7 clean after one edge", clean_map, a);
        check_vec("R7 trig not yet", trig_map, '0);
        up_hits = '0;
        lo_hits = '0;
        step();
        check_vec("R7 trig after two edges", trig_map, a);
        check_vec("R7 clean follows new input", clean_map, '0);
        step();
        check_vec("R7 trig clears", trig_map, '0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_cluster();
        t_edges();
        t_square();
        t_vetoed();
        t_wide();
        t_mask();
        t_chain();
        t_slave();
        t_latency();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule